// File: doc/BRIEF.md
# Supply Voltage Monitor Event Controller

This block supervises six supply rails. Each rail reaches the block as a digitized level code. Each rail has its own control register, which holds an enable bit and a threshold. When software enables a rail, the rail spends a fixed settling interval before its comparisons count. From then on, every crossing of the threshold is latched as a direction-specific event flag. A rising crossing sets a rise flag and a falling crossing sets a fall flag.

Software reads a status word, a flag word and a mask word over a simple single-cycle register bus. The status word shows which rails are enabled and whether all enabled rails have settled. The flag word holds the event flags, and the mask word selects which flags can raise the interrupt. Flags are sticky and are cleared by writing ones to a clear address. One rail, channel 5, uses separate upper and lower thresholds, so slow noise inside the band between them cannot toggle its state. The interrupt line is registered.

Top module: `vmon_evt_ctrl`

## Requirements
- R1: After reset, the status word (address 0) reads 0x01, the flag word (address 1) reads 0, the mask word (address 3) reads 0, and `irq_o` is low.
- R2: Status bit k+1 mirrors the enable bit of channel k. The I/O supply rail is channel 3, so its enable appears at status bit 4. Writes to address 0 change nothing.
- R3: Status bit 0 reads 1 only when every enabled channel has settled. A channel settles RDY_DLY (4) cycles after its enable becomes visible. A level that is already above threshold when the channel is enabled raises no flag.
- R4: The control register of channel k sits at address 4+k: enable in bit 0, threshold in bits 15:8. A level counts as above when it is greater than or equal to the threshold. A below-to-above move sets rise flag k, at flag-word bit k. An above-to-below move sets fall flag k, at flag-word bit 6+k. The flag is visible one cycle after the level changes.
- R5: Flags stay set until a 1 is written to the same bit position at the clear address (address 2). Zero bits in such a write leave their flags unchanged.
- R6: When a crossing sets a flag in the same cycle that a clear write targets that flag, the flag ends up set.
- R7: A disabled channel never sets either of its flags, whatever its level does.
- R8: Channel 5 also holds an upper threshold in control bits 23:16. Bits 15:8 serve as its lower threshold. Its rise needs a level at or above the upper threshold, and its fall needs a level below the lower threshold. Moves inside the band set nothing.
- R9: `irq_o` is the OR over all flag bits ANDed with the same bits of the mask word. It lags the flag word by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| lvl_i | input | 48 | Six 8-bit level codes, channel k in bits 8k+7:8k |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two things can land on the same flag bit in the same cycle: a threshold crossing that sets the flag, and a write to the clear address that resets it. The bench first drives channel 3 below threshold so its fall flag is set. It then moves the level back above threshold on the very cycle that a clear write targets both the rise and fall bits of that channel. The expected result is that the rise flag survives and the fall flag is cleared. A one-cycle skew in either path would show up as a wrong flag word on the next read.

// File: rtl/vmon_evt_ctrl.sv
module vmon_evt_ctrl #(
  parameter int NCH     = 6,
  parameter int CODE_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int RDY_DLY = 4,
  parameter int HYST_CH = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NCH*CODE_W-1:0] lvl_i,
  output logic                  irq_o
);
  localparam int CNT_W  = $clog2(RDY_DLY + 1);
  localparam int LO_POS = 8;
  localparam int HI_POS = 16;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(3);
  localparam int A_CTRL = 4;

  logic [NCH-1:0]      en, rdy, above, ev_rise, ev_fall;
  logic [CODE_W-1:0]   lo_thr [NCH];
  logic [CODE_W-1:0]   hi_thr [NCH];
  logic [CODE_W-1:0]   lvl    [NCH];
  logic [2*NCH-1:0]    flg, ien, clr_mask;
  logic                all_rdy;

  assign clr_mask = (we && addr == A_CLR) ? wdata[2*NCH-1:0] : '0;
  assign all_rdy  = &(~en | rdy);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             ctrl_we, at_hi, below_lo, live;

    assign lvl[i]   = lvl_i[i*CODE_W +: CODE_W];
    assign ctrl_we  = we && addr == ADDR_W'(A_CTRL + i);
    assign at_hi    = lvl[i] >= hi_thr[i];
    assign below_lo = lvl[i] < lo_thr[i];
    assign rdy[i]   = cnt == CNT_W'(RDY_DLY);
    assign live     = en[i] && rdy[i];
    assign ev_rise[i] = live && !above[i] && at_hi;
    assign ev_fall[i] = live && above[i] && below_lo;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]     <= 1'b0;
        lo_thr[i] <= '0;
        hi_thr[i] <= '0;
      end else if (ctrl_we) begin
        en[i]     <= wdata[0];
        lo_thr[i] <= wdata[LO_POS +: CODE_W];
        hi_thr[i] <= (i == HYST_CH) ? wdata[HI_POS +: CODE_W] : wdata[LO_POS +: CODE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                      cnt <= '0;
      else if (!en[i])                 cnt <= '0;
      else if (cnt != CNT_W'(RDY_DLY)) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          above[i] <= 1'b0;
      else if (!live)      above[i] <= at_hi;
      else if (ev_rise[i]) above[i] <= 1'b1;
      else if (ev_fall[i]) above[i] <= 1'b0;
    end

    a_r3_settle_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy[i]) |-> $past(en[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg   <= '0;
      ien   <= '0;
      irq_o <= 1'b0;
    end else begin
      flg   <= (flg & ~clr_mask) | {ev_fall, ev_rise};
      irq_o <= |(flg & ien);
      if (we && addr == A_IEN) ien <= wdata[2*NCH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: begin
        rdata[0]     = all_rdy;
        rdata[NCH:1] = en;
      end
      A_FLAG: rdata[2*NCH-1:0] = flg;
      A_IEN:  rdata[2*NCH-1:0] = ien;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr == ADDR_W'(A_CTRL + i)) begin
            rdata[0]               = en[i];
            rdata[LO_POS +: CODE_W] = lo_thr[i];
            rdata[HI_POS +: CODE_W] = hi_thr[i];
          end
        end
      end
    endcase
  end

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flg) & ~$past(clr_mask) & ~flg) == '0));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg & ~$past(flg) & ~{$past(en), $past(en)}) == '0));

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg[NCH-1:0] & ~$past(flg[NCH-1:0]) &
               flg[2*NCH-1:NCH] & ~$past(flg[2*NCH-1:NCH])) == '0));

  a_r8_hyst_rise_upper: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[HYST_CH]) |-> $past(lvl[HYST_CH] >= hi_thr[HYST_CH]));

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(flg & ien)));
endmodule

// File: tb/vmon_evt_ctrl_tb.sv
module vmon_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [47:0] lvl_i;
  logic        irq_o;
  logic [7:0]  lv [6];
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  always_comb for (int k = 0; k < 6; k++) lvl_i[k*8 +: 8] = lv[k];

  vmon_evt_ctrl u_dut (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
                       .rdata(rdata), .lvl_i(lvl_i), .irq_o(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 status", 4'd0, 32'h01);
    chk_reg("R1 flags", 4'd1, 32'h0);
    chk_reg("R1 mask", 4'd3, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_enable_ready();
    lv[3] = 8'd200;
    wr(4'd7, 32'h0000_6401);
    step(3);
    chk_reg("R3 not yet settled", 4'd0, 32'h10);
    step();
    chk_reg("R3 settled", 4'd0, 32'h11);
    chk_reg("R3 no spurious flag", 4'd1, 32'h0);
    wr(4'd0, 32'hFF);
    chk_reg("R2 status write ignored", 4'd0, 32'h11);
  endtask

  task automatic t_rise_fall();
    lv[3] = 8'd50; step();
    chk_reg("R4 fall flag", 4'd1, 32'h200);
    lv[3] = 8'd150; step();
    chk_reg("R4 rise flag", 4'd1, 32'h208);
    lv[0] = 8'd0;
    wr(4'd4, 32'h0000_5001);
    step(5);
    lv[0] = 8'd79; step();
    chk_reg("R4 just below threshold", 4'd1, 32'h208);
    lv[0] = 8'd80; step();
    chk_reg("R4 equal counts as above", 4'd1, 32'h209);
  endtask

  task automatic t_clear();
    wr(4'd2, 32'h0);
    chk_reg("R5 zero clear no effect", 4'd1, 32'h209);
    wr(4'd2, 32'h8);
    chk_reg("R5 selective clear", 4'd1, 32'h201);
    wr(4'd2, 32'hFFF);
    chk_reg("R5 clear all", 4'd1, 32'h0);
  endtask

  task automatic t_collide();
    lv[3] = 8'd50; step();
    chk_reg("R6 setup fall", 4'd1, 32'h200);
    lv[3] = 8'd150;
    wr(4'd2, 32'h208);
    chk_reg("R6 set beats clear", 4'd1, 32'h008);
    wr(4'd2, 32'hFFF);
  endtask

  task automatic t_disabled();
    lv[1] = 8'd0; step();
    lv[1] = 8'd255; step();
    lv[1] = 8'd0; step();
    chk_reg("R7 never-enabled channel quiet", 4'd1, 32'h0);
    wr(4'd7, 32'h0000_6400);
    chk_reg("R2 io rail bit clears", 4'd0, 32'h03);
    lv[3] = 8'd10; step();
    lv[3] = 8'd250; step();
    chk_reg("R7 disabled channel quiet", 4'd1, 32'h0);
  endtask

  task automatic t_hyst();
    lv[5] = 8'd0;
    wr(4'd9, 32'h0096_6401);
    step(5);
    lv[5] = 8'd120; step();
    chk_reg("R8 inside band no rise", 4'd1, 32'h0);
    lv[5] = 8'd150; step();
    chk_reg("R8 rise at upper", 4'd1, 32'h020);
    wr(4'd2, 32'hFFF);
    lv[5] = 8'd120; step();
    chk_reg("R8 inside band no fall", 4'd1, 32'h0);
    lv[5] = 8'd99; step();
    chk_reg("R8 fall below lower", 4'd1, 32'h800);
    lv[5] = 8'd140; step();
    chk_reg("R8 below upper no rise", 4'd1, 32'h800);
    wr(4'd2, 32'hFFF);
  endtask

  task automatic t_irq();
    wr(4'd3, 32'h800);
    chk_reg("R9 mask readback", 4'd3, 32'h800);
    lv[5] = 8'd160; step(2);
    chk("R9 masked flag no irq", {31'd0, irq_o}, 32'd0);
    lv[5] = 8'd50; step();
    chk("R9 irq lags flag", {31'd0, irq_o}, 32'd0);
    step();
    chk("R9 irq asserted", {31'd0, irq_o}, 32'd1);
    wr(4'd2, 32'h800);
    chk("R9 irq holds one cycle after clear", {31'd0, irq_o}, 32'd1);
    step();
    chk("R9 irq released", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) lv[k] = 8'd0;
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_enable_ready();
    t_rise_fall();
    t_clear();
    t_collide();
    t_disabled();
    t_hyst();
    t_irq();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule